// File: doc/BRIEF.md
# DIMM Temperature Holding Register

This block keeps the current temperature byte for one memory module. Throttling and refresh-rate logic further down read that byte. Each cycle the byte is reloaded from one of two hardware sources, picked by a select input. The first source is a sensor reading in signed fixed point. Before it is stored, a negative reading becomes zero, the fractional bits are dropped and readings above 127 degrees are held at 127. The second source is a byte supplied by firmware, which is stored as it is.

A configuration write port lets debug software force a test value into the byte, but only while the lock input is low. A write that targets the byte while the lock is high is refused. The stored byte then stays on its hardware source, and an abort pulse is raised for one cycle. Out of reset the byte holds 85 degrees, so refresh runs at the safe rate until a real reading arrives.

The block also keeps a sticky event flag. The flag is set when the over-temperature input rises. It is cleared only by a write that carries the clear bit.

Top module: `dimm_temp_reg`

## Requirements
- R1: While reset is high, and on the first cycle after it, `temp_o` is 85 (0x55), `evt_o` is 0 and `wr_abort_o` is 0.
- R2: With `src_sel_i` = 0 (sensor source) and no accepted write, `temp_o` shows the integer part of `sens_raw_i` one cycle later. `sens_raw_i` is a 16-bit two's-complement value whose low 4 bits are fractional, and the fraction is truncated.
- R3: A negative sensor reading, including a negative reading with a fractional part, is stored as 0.
- R4: A sensor reading whose integer part is above 127 is stored as 127.
- R5: With `src_sel_i` = 1 (firmware source) and no accepted write, `temp_o` equals `fw_temp_i` one cycle later, including values above 127.
- R6: A byte write (`cfg_wr_i` = 1, `cfg_wr_temp_i` = 1) while `lock_i` = 0 stores `cfg_wdata_i` one cycle later, taking priority over the hardware source. On the next cycle without such a write, the hardware source is back in the byte.
- R7: A byte write while `lock_i` = 1 leaves the byte following its hardware source and drives `wr_abort_o` high for exactly the following cycle. `wr_abort_o` is 0 after any cycle that had no locked byte write.
- R8: `evt_o` is set one cycle after `overtemp_i` is sampled high when it was sampled low on the previous cycle. The sample before reset release counts as low. A level that stays high does not set the flag again.
- R9: `evt_o` stays set until a cycle with `cfg_wr_i` = 1 and `cfg_evt_clr_i` = 1, which clears it one cycle later whatever the lock. If a rising edge and a clear fall on the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sens_raw_i | input | 16 | Sensor reading, signed, 4 fractional bits |
| fw_temp_i | input | 8 | Firmware-supplied temperature byte |
| src_sel_i | input | 1 | Source select: 0 sensor, 1 firmware |
| lock_i | input | 1 | 1 makes the byte read-only to writes |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wr_temp_i | input | 1 | Write targets the temperature byte |
| cfg_wdata_i | input | 8 | Test value for the temperature byte |
| cfg_evt_clr_i | input | 1 | Write-1 clear bit for the event flag |
| overtemp_i | input | 1 | Over-temperature indication |
| temp_o | output | 8 | Stored temperature byte |
| evt_o | output | 1 | Sticky over-temperature event flag |
| wr_abort_o | output | 1 | One-cycle pulse after a refused byte write |

## Verification
The sensor path is swept over all 65536 input codes, and every result is compared with an arithmetic model. This single sweep separates correct truncation from rounding, the zero clamp on negative codes (fractional ones included) from sign errors, and saturation from wrap-around. The firmware byte is swept through all 256 values, so a source mux stuck on the sensor path shows up, and so does clamping that must not happen. An unlocked write of every byte value is made over a constant sensor reading, followed by locked writes of values that differ from that reading. Together these tell write priority, hardware take-back and refusal apart. Short sequences of held-high, toggling and simultaneous over-temperature and clear stimulus separate edge detection from level detection and show the set-wins rule.

// File: rtl/dtemp_pkg.sv
package dtemp_pkg;

    typedef enum logic {
        SRC_SENSOR = 1'b0,
        SRC_FW     = 1'b1
    } src_e;

endpackage

// File: rtl/temp_sanitize.sv
module temp_sanitize #(
    parameter int IN_W    = 16,
    parameter int FRAC_W  = 4,
    parameter int OUT_W   = 8,
    parameter int MAX_VAL = 127
) (
    input  logic [IN_W-1:0]  raw_i,
    output logic [OUT_W-1:0] clean_o
);

    localparam logic signed [IN_W-1:0] MAX_S = IN_W'(MAX_VAL);

    logic signed [IN_W-1:0] whole;

    always_comb begin
        whole = $signed(raw_i) >>> FRAC_W;
        if (whole < 0) begin
            clean_o = '0;
        end else if (whole > MAX_S) begin
            clean_o = OUT_W'(MAX_VAL);
        end else begin
            clean_o = whole[OUT_W-1:0];
        end
    end

    always_comb begin
        assert_clamp_range_R4: assert (clean_o <= OUT_W'(MAX_VAL));
    end

endmodule

// File: rtl/temp_event_flag.sv
module temp_event_flag (
    input  logic clk,
    input  logic rst,
    input  logic ot_i,
    input  logic clr_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
        logic ot_prev;
    } evt_state_t;

    evt_state_t st_d, st_q;
    logic       rise;

    always_comb begin
        st_d         = st_q;
        rise         = ot_i && !st_q.ot_prev;
        st_d.ot_prev = ot_i;
        if (rise) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    assert_set_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
        (ot_i && !st_q.ot_prev) |=> flag_o);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !(ot_i && !st_q.ot_prev)) |=> !flag_o);

    assert_no_spurious_set_R8: assert property (@(posedge clk) disable iff (rst)
        (!flag_o && !(ot_i && !st_q.ot_prev)) |=> !flag_o);

endmodule

// File: rtl/dimm_temp_reg.sv
module dimm_temp_reg #(
    parameter int SENS_W     = 16,
    parameter int FRAC_W     = 4,
    parameter int TEMP_W     = 8,
    parameter int TEMP_MAX   = 127,
    parameter int RESET_TEMP = 85
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SENS_W-1:0] sens_raw_i,
    input  logic [TEMP_W-1:0] fw_temp_i,
    input  logic              src_sel_i,
    input  logic              lock_i,
    input  logic              cfg_wr_i,
    input  logic              cfg_wr_temp_i,
    input  logic [TEMP_W-1:0] cfg_wdata_i,
    input  logic              cfg_evt_clr_i,
    input  logic              overtemp_i,
    output logic [TEMP_W-1:0] temp_o,
    output logic              evt_o,
    output logic              wr_abort_o
);

    import dtemp_pkg::*;

    localparam logic [TEMP_W-1:0] RST_VAL = TEMP_W'(RESET_TEMP);

    typedef struct packed {
        logic [TEMP_W-1:0] temp;
        logic              abort;
    } reg_state_t;

    reg_state_t        st_d, st_q;
    logic [TEMP_W-1:0] sens_clean;
    logic [TEMP_W-1:0] hw_val;
    logic              byte_wr;
    logic              wr_ok;
    logic              wr_refused;
    logic              evt_clr;
    src_e              src;

    temp_sanitize #(
        .IN_W    (SENS_W),
        .FRAC_W  (FRAC_W),
        .OUT_W   (TEMP_W),
        .MAX_VAL (TEMP_MAX)
    ) u_sanitize (
        .raw_i   (sens_raw_i),
        .clean_o (sens_clean)
    );

    temp_event_flag u_event (
        .clk    (clk),
        .rst    (rst),
        .ot_i   (overtemp_i),
        .clr_i  (evt_clr),
        .flag_o (evt_o)
    );

    always_comb begin
        src        = src_e'(src_sel_i);
        byte_wr    = cfg_wr_i && cfg_wr_temp_i;
        wr_ok      = byte_wr && !lock_i;
        wr_refused = byte_wr && lock_i;
        evt_clr    = cfg_wr_i && cfg_evt_clr_i;
        hw_val     = (src == SRC_FW) ? fw_temp_i : sens_clean;

        st_d       = st_q;
        st_d.abort = wr_refused;
        if (wr_ok) begin
            st_d.temp = cfg_wdata_i;
        end else begin
            st_d.temp = hw_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.temp  <= RST_VAL;
            st_q.abort <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign temp_o     = st_q.temp;
    assign wr_abort_o = st_q.abort;

    assert_write_taken_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_i && cfg_wr_temp_i && !lock_i) |=> (temp_o == $past(cfg_wdata_i)));

    assert_abort_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_i && cfg_wr_temp_i && lock_i) |=> wr_abort_o);

    assert_no_abort_R7: assert property (@(posedge clk) disable iff (rst)
        !(cfg_wr_i && cfg_wr_temp_i && lock_i) |=> !wr_abort_o);

    assert_fw_path_R5: assert property (@(posedge clk) disable iff (rst)
        (src_sel_i && !(cfg_wr_i && cfg_wr_temp_i && !lock_i)) |=> (temp_o == $past(fw_temp_i)));

    assert_sensor_range_R4: assert property (@(posedge clk) disable iff (rst)
        (!src_sel_i && !(cfg_wr_i && cfg_wr_temp_i && !lock_i)) |=> (temp_o <= TEMP_W'(TEMP_MAX)));

endmodule

// File: tb/tb_dimm_temp_reg.sv
module tb_dimm_temp_reg;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] sens_raw_i = '0;
    logic [7:0]  fw_temp_i = '0;
    logic        src_sel_i = 1'b0;
    logic        lock_i = 1'b0;
    logic        cfg_wr_i = 1'b0;
    logic        cfg_wr_temp_i = 1'b0;
    logic [7:0]  cfg_wdata_i = '0;
    logic        cfg_evt_clr_i = 1'b0;
    logic        overtemp_i = 1'b0;
    logic [7:0]  temp_o;
    logic        evt_o;
    logic        wr_abort_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dimm_temp_reg dut (
        .clk           (clk),
        .rst           (rst),
        .sens_raw_i    (sens_raw_i),
        .fw_temp_i     (fw_temp_i),
        .src_sel_i     (src_sel_i),
        .lock_i        (lock_i),
        .cfg_wr_i      (cfg_wr_i),
        .cfg_wr_temp_i (cfg_wr_temp_i),
        .cfg_wdata_i   (cfg_wdata_i),
        .cfg_evt_clr_i (cfg_evt_clr_i),
        .overtemp_i    (overtemp_i),
        .temp_o        (temp_o),
        .evt_o         (evt_o),
        .wr_abort_o    (wr_abort_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_sensor(input logic [15:0] v);
        int s;
        int q;
        s = int'($signed(v));
        if (s < 0) return 0;
        q = s / 16;
        if (q > 127) return 127;
        return q;
    endfunction

    task automatic wr(input bit temp_en, input bit clr, input logic [7:0] d);
        cfg_wr_i      = 1'b1;
        cfg_wr_temp_i = temp_en;
        cfg_evt_clr_i = clr;
        cfg_wdata_i   = d;
    endtask

    task automatic wr_idle();
        cfg_wr_i      = 1'b0;
        cfg_wr_temp_i = 1'b0;
        cfg_evt_clr_i = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with a sensor value that would differ
        sens_raw_i = 16'h0140;
        step();
        step();
        chk("R1 temp in reset", int'(temp_o), 85);
        chk("R1 evt in reset", int'(evt_o), 0);
        chk("R1 abort in reset", int'(wr_abort_o), 0);
        rst = 1'b0;
        chk("R1 temp at release", int'(temp_o), 85);
        step();
        chk("R2 first sensor load", int'(temp_o), 20);

        // R2, R3, R4: full sweep of sensor codes
        for (int i = 0; i < 65536; i++) begin
            sens_raw_i = i[15:0];
            step();
            chk("R2/R3/R4 sensor sweep", int'(temp_o), model_sensor(i[15:0]));
        end
        sens_raw_i = 16'hFFF8;
        step();
        chk("R3 negative fraction", int'(temp_o), 0);
        sens_raw_i = 16'h7FFF;
        step();
        chk("R4 saturate top", int'(temp_o), 127);
        sens_raw_i = 16'h07FF;
        step();
        chk("R2 truncate 127.9375", int'(temp_o), 127);
        sens_raw_i = 16'h0800;
        step();
        chk("R4 saturate 128", int'(temp_o), 127);

        // R5: firmware source sweep
        src_sel_i = 1'b1;
        for (int v = 0; v < 256; v++) begin
            fw_temp_i = v[7:0];
            step();
            chk("R5 firmware byte", int'(temp_o), v);
        end
        src_sel_i = 1'b0;

        // R6: unlocked writes over a constant sensor value of 30
        sens_raw_i = 16'h01E8;
        for (int v = 0; v < 256; v++) begin
            wr(1'b1, 1'b0, v[7:0]);
            step();
            chk("R6 write stored", int'(temp_o), v);
            chk("R7 no abort when unlocked", int'(wr_abort_o), 0);
        end
        wr_idle();
        step();
        chk("R6 hardware takes back", int'(temp_o), 30);

        // R7: locked writes are refused
        lock_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] d;
            d = (k == 0) ? 8'd0 : (k == 1) ? 8'd85 : (k == 2) ? 8'd200 : 8'd255;
            wr(1'b1, 1'b0, d);
            step();
            chk("R7 locked value kept", int'(temp_o), 30);
            chk("R7 abort pulse", int'(wr_abort_o), 1);
            wr_idle();
            step();
            chk("R7 abort ends", int'(wr_abort_o), 0);
            chk("R7 locked value after", int'(temp_o), 30);
        end
        wr(1'b1, 1'b0, 8'd99);
        step();
        chk("R7 back-to-back abort 1", int'(wr_abort_o), 1);
        step();
        chk("R7 back-to-back abort 2", int'(wr_abort_o), 1);
        chk("R7 back-to-back value", int'(temp_o), 30);
        wr_idle();
        step();
        chk("R7 back-to-back end", int'(wr_abort_o), 0);

        // R8, R9: event flag
        lock_i = 1'b0;
        chk("R8 flag idle", int'(evt_o), 0);
        overtemp_i = 1'b1;
        step();
        chk("R8 set on rise", int'(evt_o), 1);
        wr(1'b0, 1'b1, 8'd0);
        step();
        chk("R9 cleared by write-1", int'(evt_o), 0);
        chk("R9 clear does not touch byte", int'(temp_o), 30);
        wr_idle();
        step();
        chk("R8 held level no reset", int'(evt_o), 0);
        overtemp_i = 1'b0;
        step();
        chk("R8 falling no set", int'(evt_o), 0);
        overtemp_i = 1'b1;
        step();
        chk("R8 second rise", int'(evt_o), 1);
        overtemp_i = 1'b0;
        step();
        chk("R9 sticky after drop", int'(evt_o), 1);
        wr(1'b0, 1'b0, 8'd0);
        step();
        chk("R9 write of 0 keeps flag", int'(evt_o), 1);
        wr(1'b0, 1'b1, 8'd0);
        step();
        chk("R9 clear", int'(evt_o), 0);
        overtemp_i = 1'b1;
        wr(1'b0, 1'b1, 8'd0);
        step();
        chk("R9 set wins over clear", int'(evt_o), 1);
        lock_i = 1'b1;
        wr(1'b0, 1'b1, 8'd0);
        step();
        chk("R9 clear while locked", int'(evt_o), 0);
        chk("R7 clear-only write no abort", int'(wr_abort_o), 0);
        wr_idle();
        lock_i = 1'b0;

        // R1: reset again from a busy state
        wr(1'b1, 1'b0, 8'd7);
        step();
        overtemp_i = 1'b0;
        step();
        overtemp_i = 1'b1;
        lock_i = 1'b1;
        rst = 1'b1;
        step();
        chk("R1 re-reset temp", int'(temp_o), 85);
        chk("R1 re-reset evt", int'(evt_o), 0);
        chk("R1 re-reset abort", int'(wr_abort_o), 0);
        wr_idle();
        rst = 1'b0;
        step();
        chk("R8 high at release counts as rise", int'(evt_o), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule